// File: doc/BRIEF.md
# Eight-Line Vectored Interrupt Controller

The controller gathers eight interrupt request lines, decides which of them should interrupt the processor, and drives a single request output. When the processor acknowledges with two strobes, the first strobe marks the winning line as in service and the second places an 8-bit vector on the data output. The vector is a programmed base in the upper five bits with the line number in the lower three.

Software configures it through a two-address port. `addr` = 0 carries the first initialization word and the runtime command words. `addr` = 1 carries the remaining initialization words and the mask. Once configured, the block tracks pending, in-service and masked lines. It supports fully nested priority, rotating priority, automatic or commanded end of service, and a polled read that needs no acknowledge strobes. Cascading is not supported, and the cascade output is held at zero.

Top module: `irq_ctrl8`

## Requirements
- R1: Initialization starts with a write at `addr`=0 with bit 4 set (word A). Then one write at `addr`=1 (word B) follows. A second `addr`=1 write (word C, content ignored) follows only when word A bit 1 is 0. A final `addr`=1 write (word D) follows only when word A bit 0 is 1. Until that sequence completes, writes other than word A are ignored and `int_out` stays 0.
- R2: The first acknowledge strobe moves the winning line into the in-service set. One cycle after the rising edge of the second strobe, `dout_vld` is 1 and `dout` is {word B[7:3], line number}.
- R3: After word A, line 0 has the highest priority and line 7 the lowest. The highest-priority line that is pending and unmasked wins.
- R4: An `addr`=1 write after initialization loads the mask. A line with a set mask bit cannot cause `int_out`. A read at `addr`=1 returns the mask. Word A clears the mask.
- R5: Word A bit 3 = 1 makes the pending register follow the input levels. Bit 3 = 0 latches a rising edge until that line is acknowledged, so an input that stays high does not request again.
- R6: When word D bit 1 is 1, the in-service bit is cleared at the second strobe. Otherwise it stays set until an end-of-service command clears it.
- R7: An end-of-service command is an `addr`=0 write with bits 4:3 = 00 and an opcode in bits 7:5. Opcode 001 clears the highest-priority in-service bit. Opcode 011 clears the bit named in bits 2:0.
- R8: Opcode 101 acts like 001 and also makes the cleared line the lowest priority. Opcode 111 acts like 011 and makes the named line the lowest priority. Opcode 110 only makes line bits 2:0 the lowest priority.
- R9: `int_out` is 1 only when the winning line has strictly higher priority than every line in service.
- R10: An `addr`=0 write with bits 4:3 = 01 is a read-control command. Bit 2 arms a poll. The next `addr`=0 read then returns {pending, 0000, line} (all zero when nothing is pending) and marks that line in service. Bit 1 = 1 selects what other `addr`=0 reads return: in-service when bit 0 = 1, pending when bit 0 = 0.
- R11: An acknowledge with no line pending produces vector {base, 7} and leaves the in-service set unchanged.
- R12: `cas_out` is always 0.
- R13: After reset, `int_out` and `dout_vld` are 0, the mask reads 0, and the block waits for word A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| irq_in | input | 8 | request lines |
| wr_en | input | 1 | register write strobe |
| rd_en | input | 1 | register read strobe |
| addr | input | 1 | register port address |
| wdata | input | 8 | write data |
| ack_in | input | 1 | acknowledge strobe from the processor |
| dout | output | 8 | read data or vector, registered |
| dout_vld | output | 1 | dout valid for one cycle |
| int_out | output | 1 | interrupt request to the processor |
| cas_out | output | 3 | cascade lines, held at 0 |

## Verification
The ports show a wrong priority pointer or a stale in-service bit at the next acknowledge, as a wrong line number in the vector. They also show it within two cycles as a request that is raised or withheld against the nesting rule. A wrong pending register in edge mode shows as a request that repeats or never clears, which the register readback exposes directly. Any defect in the initialization sequencer misplaces the base, the mask or the automatic-end bit, and the first vector or mask readback after setup reveals it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int IRQ_N  = 8;
  localparam int LVL_W  = $clog2(IRQ_N);
  localparam int DW     = 8;
  localparam int BASE_W = DW - LVL_W;

  typedef enum logic [2:0] {
    ST_W1, ST_W2, ST_W3, ST_W4, ST_RUN
  } init_st_e;

  typedef enum logic [2:0] {
    OP_NSEOI  = 3'b001,
    OP_SEOI   = 3'b011,
    OP_ROT_NS = 3'b101,
    OP_ROT_S  = 3'b111,
    OP_SETPRI = 3'b110
  } op_e;

  typedef struct packed {
    logic             vld;
    logic [LVL_W-1:0] lvl;
    logic [LVL_W-1:0] rank;
  } pick_t;

  // Highest-priority set bit, counting from the line just above 'lo'.
  function automatic pick_t pick_first(input logic [IRQ_N-1:0] v,
                                       input logic [LVL_W-1:0] lo);
    pick_t p;
    logic [LVL_W-1:0] idx;
    p = '0;
    for (int j = IRQ_N - 1; j >= 0; j--) begin
      idx = lo + LVL_W'(j) + LVL_W'(1);
      if (v[idx]) begin
        p.vld  = 1'b1;
        p.lvl  = idx;
        p.rank = LVL_W'(j);
      end
    end
    return p;
  endfunction
endpackage

// File: rtl/irqc_reqs.sv
module irqc_reqs
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [IRQ_N-1:0] irq_in,
  input  logic             ltim,
  input  logic             flush,
  input  logic [IRQ_N-1:0] clr,
  output logic [IRQ_N-1:0] irr
);
  logic [IRQ_N-1:0] prev;

  for (genvar i = 0; i < IRQ_N; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        prev[i] <= 1'b0;
        irr[i]  <= 1'b0;
      end else begin
        prev[i] <= irq_in[i];
        if (ltim)                       irr[i] <= irq_in[i];
        else if (flush)                 irr[i] <= 1'b0;
        else if (irq_in[i] && !prev[i]) irr[i] <= 1'b1;
        else if (clr[i])                irr[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irqc_resolve.sv
module irqc_resolve
  import irqc_pkg::*;
(
  input  logic [IRQ_N-1:0] irr,
  input  logic [IRQ_N-1:0] imr,
  input  logic [IRQ_N-1:0] isr,
  input  logic [LVL_W-1:0] lo,
  output pick_t            win,
  output pick_t            top,
  output logic             req
);
  always_comb begin
    win = pick_first(irr & ~imr, lo);
    top = pick_first(isr, lo);
    req = win.vld && (!top.vld || (win.rank < top.rank));
  end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [DW-1:0]     wdata,
  input  pick_t             top,
  output logic              ready,
  output logic              icw1_hit,
  output logic              ltim,
  output logic              aeoi,
  output logic [BASE_W-1:0] base,
  output logic [IRQ_N-1:0]  imr,
  output logic [LVL_W-1:0]  lo,
  output logic              poll,
  output logic              rd_isr,
  output logic [IRQ_N-1:0]  eoi_clr
);
  init_st_e         st;
  logic             need_w3, need_w4;
  logic             ocw2_hit, ocw3_hit;
  op_e              op;
  logic [LVL_W-1:0] fld;

  assign ready    = (st == ST_RUN);
  assign icw1_hit = wr_en && !addr && wdata[4];
  assign ocw2_hit = wr_en && !addr && ready && (wdata[4:3] == 2'b00);
  assign ocw3_hit = wr_en && !addr && ready && (wdata[4:3] == 2'b01);
  assign op       = op_e'(wdata[7:5]);
  assign fld      = wdata[LVL_W-1:0];

  always_comb begin
    eoi_clr = '0;
    if (ocw2_hit) begin
      case (op)
        OP_NSEOI, OP_ROT_NS: if (top.vld) eoi_clr[top.lvl] = 1'b1;
        OP_SEOI, OP_ROT_S:   eoi_clr[fld] = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_W1;
      need_w3 <= 1'b0;
      need_w4 <= 1'b0;
      ltim    <= 1'b0;
      aeoi    <= 1'b0;
      base    <= '0;
      imr     <= '0;
      lo      <= LVL_W'(IRQ_N - 1);
      poll    <= 1'b0;
      rd_isr  <= 1'b0;
    end else begin
      if (rd_en && !addr) poll <= 1'b0;
      if (icw1_hit) begin
        st      <= ST_W2;
        ltim    <= wdata[3];
        need_w3 <= !wdata[1];
        need_w4 <= wdata[0];
        aeoi    <= 1'b0;
        imr     <= '0;
        lo      <= LVL_W'(IRQ_N - 1);
        poll    <= 1'b0;
        rd_isr  <= 1'b0;
      end else if (wr_en && addr) begin
        case (st)
          ST_W2: begin
            base <= wdata[DW-1:LVL_W];
            st   <= need_w3 ? ST_W3 : (need_w4 ? ST_W4 : ST_RUN);
          end
          ST_W3:   st <= need_w4 ? ST_W4 : ST_RUN;
          ST_W4: begin
            aeoi <= wdata[1];
            st   <= ST_RUN;
          end
          ST_RUN:  imr <= wdata;
          default: ;
        endcase
      end else if (ocw2_hit) begin
        case (op)
          OP_ROT_NS: if (top.vld) lo <= top.lvl;
          OP_ROT_S, OP_SETPRI: lo <= fld;
          default: ;
        endcase
      end else if (ocw3_hit) begin
        if (wdata[2]) poll   <= 1'b1;
        if (wdata[1]) rd_isr <= wdata[0];
      end
    end
  end
endmodule

// File: rtl/irq_ctrl8.sv
module irq_ctrl8
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [IRQ_N-1:0] irq_in,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             addr,
  input  logic [DW-1:0]    wdata,
  input  logic             ack_in,
  output logic [DW-1:0]    dout,
  output logic             dout_vld,
  output logic             int_out,
  output logic [2:0]       cas_out
);
  logic              ready, icw1_hit, ltim, aeoi, poll, rd_isr, req;
  logic [BASE_W-1:0] base;
  logic [IRQ_N-1:0]  imr, irr, isr, eoi_clr, set_vec, aeoi_clr;
  logic [LVL_W-1:0]  lo, ack_lvl;
  pick_t             win, top;
  logic              ack_q, ack_ph, ack_hit, vec_stb;
  logic              ack_rise, ack1, ack2, poll_rd;

  assign cas_out  = '0;
  assign ack_rise = ack_in && !ack_q;
  assign ack1     = ack_rise && !ack_ph;
  assign ack2     = ack_rise && ack_ph;
  assign poll_rd  = rd_en && !addr && poll;

  irqc_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .top(top), .ready(ready), .icw1_hit(icw1_hit),
    .ltim(ltim), .aeoi(aeoi), .base(base), .imr(imr), .lo(lo),
    .poll(poll), .rd_isr(rd_isr), .eoi_clr(eoi_clr)
  );

  irqc_reqs u_reqs (
    .clk(clk), .rst(rst), .irq_in(irq_in), .ltim(ltim),
    .flush(icw1_hit), .clr(set_vec), .irr(irr)
  );

  irqc_resolve u_res (
    .irr(irr), .imr(imr), .isr(isr), .lo(lo),
    .win(win), .top(top), .req(req)
  );

  always_comb begin
    set_vec  = '0;
    aeoi_clr = '0;
    if ((ack1 || poll_rd) && win.vld) set_vec[win.lvl] = 1'b1;
    if (ack2 && aeoi && ack_hit)      aeoi_clr[ack_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || icw1_hit) isr <= '0;
    else                 isr <= (isr & ~eoi_clr & ~aeoi_clr) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      ack_ph  <= 1'b0;
      ack_hit <= 1'b0;
      ack_lvl <= '0;
    end else begin
      ack_q <= ack_in;
      if (icw1_hit) ack_ph <= 1'b0;
      else if (ack1) begin
        ack_ph  <= 1'b1;
        ack_hit <= win.vld;
        ack_lvl <= win.vld ? win.lvl : LVL_W'(IRQ_N - 1);
      end else if (ack2) ack_ph <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout     <= '0;
      dout_vld <= 1'b0;
      vec_stb  <= 1'b0;
      int_out  <= 1'b0;
    end else begin
      dout_vld <= 1'b0;
      vec_stb  <= 1'b0;
      int_out  <= ready && req;
      if (ack2) begin
        dout     <= {base, ack_lvl};
        dout_vld <= 1'b1;
        vec_stb  <= 1'b1;
      end else if (rd_en) begin
        dout_vld <= 1'b1;
        if (addr)        dout <= imr;
        else if (poll)   dout <= {win.vld, {(DW-1-LVL_W){1'b0}},
                                  win.vld ? win.lvl : {LVL_W{1'b0}}};
        else if (rd_isr) dout <= isr;
        else             dout <= irr;
      end
    end
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              addr,
  input logic [DW-1:0]     wdata,
  input logic              int_out,
  input logic [DW-1:0]     dout,
  input logic              dout_vld,
  input logic [IRQ_N-1:0]  irr,
  input logic [IRQ_N-1:0]  imr,
  input logic [IRQ_N-1:0]  isr,
  input logic              ready,
  input logic              aeoi,
  input logic              ack_hit,
  input logic [BASE_W-1:0] base,
  input logic              vec_stb,
  input logic              icw1_hit
);
  // R4
  masked_req_chk: assert property (@(posedge clk) disable iff (rst)
    int_out |-> $past(|(irr & ~imr)));

  // R4
  mask_write_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ready && wr_en && addr) |-> (imr == $past(wdata)));

  // R1
  icw1_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(icw1_hit) |-> (imr == '0 && isr == '0 && !ready));

  // R2
  vec_base_chk: assert property (@(posedge clk) disable iff (rst)
    vec_stb |-> (dout_vld && dout[DW-1:LVL_W] == base));

  // R6
  aeoi_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_stb && aeoi && ack_hit) |-> !isr[dout[LVL_W-1:0]]);

  // R13
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!int_out && !dout_vld && imr == '0 && !ready));
endmodule

bind irq_ctrl8 irqc_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .int_out(int_out), .dout(dout), .dout_vld(dout_vld), .irr(irr),
  .imr(imr), .isr(isr), .ready(ready), .aeoi(aeoi), .ack_hit(ack_hit),
  .base(base), .vec_stb(vec_stb), .icw1_hit(icw1_hit)
);

// File: tb/irq_ctrl8_bench.sv
module irq_ctrl8_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, ack_in = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] dout;
  logic       dout_vld, int_out;
  logic [2:0] cas_out;
  int checks = 0, errors = 0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  irq_ctrl8 u_irq_ctrl8 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .ack_in(ack_in), .dout(dout),
    .dout_vld(dout_vld), .int_out(int_out), .cas_out(cas_out)
  );

  // {irq, mask, expected vector (0 = no request)}; level mode, base 20h, auto end
  localparam logic [23:0] TAB [8] = '{
    {8'h01, 8'h00, 8'h20}, {8'h80, 8'h00, 8'h27},
    {8'h0C, 8'h00, 8'h22}, {8'h0C, 8'h04, 8'h23},
    {8'hF0, 8'hF0, 8'h00}, {8'hA0, 8'h20, 8'h27},
    {8'hFF, 8'h7F, 8'h27}, {8'h00, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = dout;
  endtask

  task automatic ack_pair(output logic [7:0] d);
    @(negedge clk); ack_in = 1'b1;
    @(negedge clk); ack_in = 1'b0;
    @(negedge clk); ack_in = 1'b1;
    @(negedge clk); ack_in = 1'b0;
    d = dout;
    chk("R2 vld", {7'd0, dout_vld}, 8'h01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3); rst = 1'b0; idle(1);
    chk("R13 int", {7'd0, int_out}, 8'h00);
    chk("R13 vld", {7'd0, dout_vld}, 8'h00);
    chk("R12", {5'd0, cas_out}, 8'h00);
    rd(1'b1, v); chk("R13 mask", v, 8'h00);
    irq_in = 8'hFF; idle(4);
    chk("R1 not configured", {7'd0, int_out}, 8'h00);
    wr(1'b1, 8'h55); rd(1'b1, v); chk("R1 write ignored", v, 8'h00);
    irq_in = 8'h00;

    // level, single, word D wanted
    wr(1'b0, 8'h1B); wr(1'b1, 8'h20);
    irq_in = 8'h01; idle(3);
    chk("R1 awaiting word D", {7'd0, int_out}, 8'h00);
    irq_in = 8'h00; wr(1'b1, 8'h03);

    for (int i = 0; i < 8; i++) begin
      wr(1'b1, TAB[i][15:8]);
      rd(1'b1, v); chk("R4 mask readback", v, TAB[i][15:8]);
      irq_in = TAB[i][23:16]; idle(3);
      chk("R3/R4 request", {7'd0, int_out}, {7'd0, TAB[i][7:0] != 8'h00});
      if (TAB[i][7:0] != 8'h00) begin
        ack_pair(v); chk("R2/R3 vector", v, TAB[i][7:0]);
        idle(3); chk("R6 auto end rerequest", {7'd0, int_out}, 8'h01);
      end
      irq_in = 8'h00; idle(3);
      chk("R5 level drop", {7'd0, int_out}, 8'h00);
    end
    wr(1'b0, 8'h0B); rd(1'b0, v); chk("R6 in-service empty", v, 8'h00);

    // cascade flag set: word C required; no auto end; base 40h
    wr(1'b0, 8'h19); wr(1'b1, 8'h40); wr(1'b1, 8'h55); wr(1'b1, 8'h01);
    wr(1'b1, 8'h00);
    irq_in = 8'h01; idle(3);
    chk("R1 word C sequence", {7'd0, int_out}, 8'h01);
    ack_pair(v); chk("R1 base", v, 8'h40);
    irq_in = 8'h00;
    wr(1'b0, 8'h0B); rd(1'b0, v); chk("R6 held in service", v, 8'h01);
    irq_in = 8'h08; idle(3);
    chk("R9 lower blocked", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h20); idle(3);
    chk("R7 nonspecific end", {7'd0, int_out}, 8'h01);
    ack_pair(v); chk("R2 vector", v, 8'h43);
    idle(2); chk("R9 same level", {7'd0, int_out}, 8'h00);
    irq_in = 8'h0A; idle(3);
    chk("R9 higher nests", {7'd0, int_out}, 8'h01);
    ack_pair(v); chk("R9 nested vector", v, 8'h41);
    wr(1'b0, 8'h63); rd(1'b0, v); chk("R7 specific end", v, 8'h02);
    wr(1'b0, 8'h20); rd(1'b0, v); chk("R7 nonspecific end", v, 8'h00);
    irq_in = 8'h00;

    // rotation
    wr(1'b0, 8'hC4); irq_in = 8'h21; idle(3);
    ack_pair(v); chk("R8 set priority", v, 8'h45);
    wr(1'b0, 8'hA0); idle(3);
    ack_pair(v); chk("R8 rotate nonspecific", v, 8'h40);
    wr(1'b0, 8'hE0); idle(3);
    ack_pair(v); chk("R8 rotate specific", v, 8'h45);
    wr(1'b0, 8'h20); irq_in = 8'h00; idle(2);

    // poll
    irq_in = 8'h50; idle(3);
    wr(1'b0, 8'h0C); rd(1'b0, v); chk("R10 poll word", v, 8'h84);
    rd(1'b0, v); chk("R10 poll marks service", v, 8'h10);
    wr(1'b0, 8'h20); irq_in = 8'h00; idle(3);
    wr(1'b0, 8'h0C); rd(1'b0, v); chk("R10 poll empty", v, 8'h00);
    wr(1'b0, 8'h0A); irq_in = 8'h03; idle(3);
    rd(1'b0, v); chk("R10 pending select", v, 8'h03);
    irq_in = 8'h00; idle(2);

    // edge mode, base 60h, no auto end; word A clears mask
    wr(1'b1, 8'hFF);
    wr(1'b0, 8'h13); wr(1'b1, 8'h60); wr(1'b1, 8'h00);
    rd(1'b1, v); chk("R4 word A clears mask", v, 8'h00);
    irq_in = 8'h04; idle(3);
    chk("R5 edge request", {7'd0, int_out}, 8'h01);
    ack_pair(v); chk("R5 edge vector", v, 8'h62);
    wr(1'b0, 8'h20); idle(3);
    chk("R5 held input silent", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h0A); rd(1'b0, v); chk("R5 pending cleared", v, 8'h00);
    irq_in = 8'h00; idle(2); irq_in = 8'h04; idle(3);
    chk("R5 new edge", {7'd0, int_out}, 8'h01);
    ack_pair(v); chk("R5 vector again", v, 8'h62);
    wr(1'b0, 8'h20); irq_in = 8'h00; idle(2);
    @(negedge clk); irq_in = 8'h02; @(negedge clk); irq_in = 8'h00; idle(3);
    chk("R5 pulse latched", {7'd0, int_out}, 8'h01);
    ack_pair(v); chk("R5 pulse vector", v, 8'h61);
    wr(1'b0, 8'h20); idle(3);

    ack_pair(v); chk("R11 spurious vector", v, 8'h67);
    wr(1'b0, 8'h0B); rd(1'b0, v); chk("R11 service unchanged", v, 8'h00);
    chk("R12", {5'd0, cas_out}, 8'h00);

    @(negedge clk); rst = 1'b1; irq_in = 8'hFF; idle(2); rst = 1'b0; idle(3);
    chk("R13 int after reset", {7'd0, int_out}, 8'h00);
    rd(1'b1, v); chk("R13 mask after reset", v, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule